// File: doc/BRIEF.md
# Pulse-Width Serial Bit Codec

This block encodes and decodes single symbols on a two-level serial line that uses a wired-dominant scheme. When a node drives the line, the line reads low, which is the dominant level. When no node drives it, the line floats high, which is the recessive level. A driven 0 from any node therefore overrides a 1 from every other node. The block handles symbols only: a start marker, or a data bit. Frame assembly and arbitration policy belong to the logic above it.

The transmitter takes one request at a time through a ready/request handshake.

- **Data bit.** The transmitter sends a short recessive lead, then a dominant sync segment, then a data segment. In the data segment the line stays dominant for a 0 and is released for a 1.
- **Start marker.** The transmitter holds the line dominant for a long stretch and then releases it for a recessive gap.

The receiver works as follows.

- It synchronizes the line level and times every dominant pulse.
- It sorts each pulse into one of three windows: bit 0, bit 1, or start marker.
- It reports the result with a one-cycle strobe.
- A pulse that fits no window gives a one-cycle error strobe instead.

All segment lengths are given in microseconds and scaled by a clocks-per-microsecond parameter. The same design can therefore run from different system clocks.

Top module: `pulse_bit_codec`

## Requirements
- R1: While reset is held, and from reset release until a request is taken, `txDrive` is 0 and `txReady` is 1. No receive strobe and no `txDone` is raised during this time.
- R2: A data-bit request gives a waveform on `txDrive` (1 = drive dominant) that starts in the cycle after acceptance. It is 0 for LEAD_US·C cycles, then 1 for SYNC_US·C cycles, then DATA_US·C cycles that are 1 for bit value 0 and 0 for bit value 1. C is CLK_PER_US.
- R3: A start-marker request (`txStart`=1) makes `txDrive` 1 for MARK_US·C cycles and then 0 for GAP_US·C cycles. This starts in the cycle after acceptance.
- R4: A request is taken only on a clock edge where `txReq` and `txReady` are both 1. `txReady` is 0 from the next cycle until the last segment has ended. `txDone` is high for one cycle together with the return of `txReady`. Requests made while `txReady` is 0 are ignored.
- R5: `rxLine` passes through two synchronizing flops. A receive strobe appears in the third cycle after the line returns to the recessive level (1), and not earlier.
- R6: A dominant pulse of N cycles with Z−⌊Z/4⌋ ≤ N ≤ Z+⌊Z/4⌋ raises `rxBitValid` with `rxBit`=0. Z=(SYNC_US+DATA_US)·C.
- R7: A dominant pulse with O−⌊O/4⌋ ≤ N ≤ O+⌊O/4⌋ raises `rxBitValid` with `rxBit`=1. O=SYNC_US·C.
- R8: A dominant pulse with S−⌊S/4⌋ ≤ N ≤ S+⌊S/4⌋ raises `rxStart`. S=MARK_US·C.
- R9: A dominant pulse outside all three windows raises `rxErr` and no other strobe. This includes pulses longer than the width counter can hold, which saturates.
- R10: The three receive strobes are mutually exclusive, and each lasts exactly one cycle.
- R11: When the transmit output is looped back through a wired-AND line, any sequence of start markers and bits is recovered in order. If another node holds the line dominant over a 1 bit's data segment, the receiver decodes a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txReq | input | 1 | Request to send one symbol |
| txStart | input | 1 | 1 = start marker, 0 = data bit |
| txBit | input | 1 | Data bit value for a data-bit request |
| txReady | output | 1 | Transmitter idle, request can be taken |
| txDone | output | 1 | One-cycle pulse when a symbol has finished |
| txDrive | output | 1 | 1 = pull the line dominant, 0 = release |
| rxLine | input | 1 | Line level, 0 = dominant, 1 = recessive |
| rxBitValid | output | 1 | One-cycle strobe, data bit decoded |
| rxBit | output | 1 | Decoded bit value, valid with `rxBitValid` |
| rxStart | output | 1 | One-cycle strobe, start marker decoded |
| rxErr | output | 1 | One-cycle strobe, pulse fit no window |

## Verification
**Transmit side.**
- `txDrive` follows the symbol state directly, so the first segment shows one cycle after the accepting edge.
- The bench samples every cycle of that waveform at the falling clock edge and compares it with the segment lengths.
- `txReady` and `txDone` are checked together in the cycle right after the last segment.

**Receive side.** The result is due three edges after the line is released: two synchronizer edges, then the registered strobe.
- For each pulse it drives, the bench checks that no strobe is present two cycles after release.
- It then checks for exactly one strobe of the expected kind one cycle later.
- Loopback sequences are checked through an ordered record of every strobe.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  // Transmit states double as timer segment selectors.
  typedef enum logic [2:0] {
    SEG_IDLE = 3'd0,
    SEG_MARK = 3'd1,
    SEG_GAP  = 3'd2,
    SEG_LEAD = 3'd3,
    SEG_SYNC = 3'd4,
    SEG_DATA = 3'd5
  } seg_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic tmrLoad;
    seg_e tmrSeg;
    logic drive;
    logic measClr;
  } ctrl_strobe_t;

  // Status from datapath to control.
  typedef struct packed {
    logic tmrZero;
    logic lineFall;
    logic lineRise;
  } dp_status_t;

  function automatic int winLo(input int nom);
    return nom - nom / 4;
  endfunction

  function automatic int winHi(input int nom);
    return nom + nom / 4;
  endfunction

endpackage

// File: rtl/pbc_datapath.sv
module pbc_datapath
  import pbc_pkg::*;
#(
  parameter int CLK_PER_US = 8,
  parameter int MARK_US    = 169,
  parameter int GAP_US     = 20,
  parameter int LEAD_US    = 6,
  parameter int SYNC_US    = 19,
  parameter int DATA_US    = 13,
  parameter int TMR_W      = 11,
  parameter int WIDTH_W    = 11,
  parameter int WIDTH_MAX  = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       ctl,
  input  logic               rxLine,
  output logic               txDrive,
  output dp_status_t         stat,
  output logic [WIDTH_W-1:0] pulseWidth
);

  localparam logic [WIDTH_W-1:0] WIDTH_CAP = WIDTH_W'(WIDTH_MAX);

  // Segment length minus one, in cycles.
  function automatic logic [TMR_W-1:0] segLast(input seg_e s);
    case (s)
      SEG_MARK: return TMR_W'(MARK_US * CLK_PER_US - 1);
      SEG_GAP:  return TMR_W'(GAP_US  * CLK_PER_US - 1);
      SEG_LEAD: return TMR_W'(LEAD_US * CLK_PER_US - 1);
      SEG_SYNC: return TMR_W'(SYNC_US * CLK_PER_US - 1);
      SEG_DATA: return TMR_W'(DATA_US * CLK_PER_US - 1);
      default:  return '0;
    endcase
  endfunction

  logic [TMR_W-1:0] tmrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (ctl.tmrLoad) begin
      tmrCnt <= segLast(ctl.tmrSeg);
    end else if (tmrCnt != '0) begin
      tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign txDrive = ctl.drive;

  // Line synchronizer and edge detection; recessive reset level.
  logic syncA, syncB, lvlPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      lvlPrev <= 1'b1;
    end else begin
      syncA   <= rxLine;
      syncB   <= syncA;
      lvlPrev <= syncB;
    end
  end

  // Saturating dominant-pulse width counter.
  logic [WIDTH_W-1:0] widthCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
    end else if (ctl.measClr) begin
      widthCnt <= WIDTH_W'(1);
    end else if (!syncB && widthCnt != WIDTH_CAP) begin
      widthCnt <= widthCnt + 1'b1;
    end
  end

  assign pulseWidth    = widthCnt;
  assign stat.tmrZero  = (tmrCnt == '0);
  assign stat.lineFall = lvlPrev & ~syncB;
  assign stat.lineRise = ~lvlPrev & syncB;

endmodule

// File: rtl/pbc_ctrl.sv
module pbc_ctrl
  import pbc_pkg::*;
#(
  parameter int CLK_PER_US = 8,
  parameter int MARK_US    = 169,
  parameter int SYNC_US    = 19,
  parameter int DATA_US    = 13,
  parameter int WIDTH_W    = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txReq,
  input  logic               txStart,
  input  logic               txBit,
  input  dp_status_t         stat,
  input  logic [WIDTH_W-1:0] pulseWidth,
  output ctrl_strobe_t       ctl,
  output logic               txReady,
  output logic               txDone,
  output logic               rxBitValid,
  output logic               rxBit,
  output logic               rxStart,
  output logic               rxErr
);

  localparam int ZERO_NOM  = (SYNC_US + DATA_US) * CLK_PER_US;
  localparam int ONE_NOM   = SYNC_US * CLK_PER_US;
  localparam int START_NOM = MARK_US * CLK_PER_US;

  localparam logic [WIDTH_W-1:0] ZERO_LO  = WIDTH_W'(winLo(ZERO_NOM));
  localparam logic [WIDTH_W-1:0] ZERO_HI  = WIDTH_W'(winHi(ZERO_NOM));
  localparam logic [WIDTH_W-1:0] ONE_LO   = WIDTH_W'(winLo(ONE_NOM));
  localparam logic [WIDTH_W-1:0] ONE_HI   = WIDTH_W'(winHi(ONE_NOM));
  localparam logic [WIDTH_W-1:0] START_LO = WIDTH_W'(winLo(START_NOM));
  localparam logic [WIDTH_W-1:0] START_HI = WIDTH_W'(winHi(START_NOM));

  // ---------------- transmit sequencer ----------------
  seg_e state, stateNxt;
  logic bitHold;
  logic doneNxt;

  always_comb begin
    stateNxt = state;
    doneNxt  = 1'b0;
    unique case (state)
      SEG_IDLE: if (txReq) stateNxt = txStart ? SEG_MARK : SEG_LEAD;
      SEG_MARK: if (stat.tmrZero) stateNxt = SEG_GAP;
      SEG_GAP:  if (stat.tmrZero) begin stateNxt = SEG_IDLE; doneNxt = 1'b1; end
      SEG_LEAD: if (stat.tmrZero) stateNxt = SEG_SYNC;
      SEG_SYNC: if (stat.tmrZero) stateNxt = SEG_DATA;
      SEG_DATA: if (stat.tmrZero) begin stateNxt = SEG_IDLE; doneNxt = 1'b1; end
      default:  stateNxt = SEG_IDLE;
    endcase
  end

  always_comb begin
    ctl.tmrLoad = (stateNxt != state) && (stateNxt != SEG_IDLE);
    ctl.tmrSeg  = stateNxt;
    ctl.drive   = (state == SEG_MARK) || (state == SEG_SYNC) ||
                  ((state == SEG_DATA) && !bitHold);
    ctl.measClr = stat.lineFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEG_IDLE;
      bitHold <= 1'b0;
      txDone  <= 1'b0;
    end else begin
      state  <= stateNxt;
      txDone <= doneNxt;
      if (state == SEG_IDLE && txReq) bitHold <= txBit;
    end
  end

  assign txReady = (state == SEG_IDLE);

  // ---------------- receive classifier ----------------
  logic measuring;
  logic inZero, inOne, inStart, classify;

  always_comb begin
    inZero   = (pulseWidth >= ZERO_LO)  && (pulseWidth <= ZERO_HI);
    inOne    = (pulseWidth >= ONE_LO)   && (pulseWidth <= ONE_HI);
    inStart  = (pulseWidth >= START_LO) && (pulseWidth <= START_HI);
    classify = stat.lineRise && measuring;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measuring  <= 1'b0;
      rxBitValid <= 1'b0;
      rxBit      <= 1'b0;
      rxStart    <= 1'b0;
      rxErr      <= 1'b0;
    end else begin
      if (stat.lineFall)      measuring <= 1'b1;
      else if (stat.lineRise) measuring <= 1'b0;
      rxBitValid <= classify && (inZero || inOne);
      rxStart    <= classify && inStart;
      rxErr      <= classify && !(inZero || inOne || inStart);
      if (classify && (inZero || inOne)) rxBit <= inOne;
    end
  end

endmodule

// File: rtl/pulse_bit_codec.sv
module pulse_bit_codec
  import pbc_pkg::*;
#(
  parameter int CLK_PER_US = 8,
  parameter int MARK_US    = 169,
  parameter int GAP_US     = 20,
  parameter int LEAD_US    = 6,
  parameter int SYNC_US    = 19,
  parameter int DATA_US    = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic txReq,
  input  logic txStart,
  input  logic txBit,
  output logic txReady,
  output logic txDone,
  output logic txDrive,
  input  logic rxLine,
  output logic rxBitValid,
  output logic rxBit,
  output logic rxStart,
  output logic rxErr
);

  localparam int TMR_W     = $clog2(MARK_US * CLK_PER_US + 1);
  localparam int WIDTH_MAX = winHi(MARK_US * CLK_PER_US) + 1;
  localparam int WIDTH_W   = $clog2(WIDTH_MAX + 1);

  ctrl_strobe_t       ctl;
  dp_status_t         stat;
  logic [WIDTH_W-1:0] pulseWidth;

  pbc_ctrl #(
    .CLK_PER_US (CLK_PER_US),
    .MARK_US    (MARK_US),
    .SYNC_US    (SYNC_US),
    .DATA_US    (DATA_US),
    .WIDTH_W    (WIDTH_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txReq      (txReq),
    .txStart    (txStart),
    .txBit      (txBit),
    .stat       (stat),
    .pulseWidth (pulseWidth),
    .ctl        (ctl),
    .txReady    (txReady),
    .txDone     (txDone),
    .rxBitValid (rxBitValid),
    .rxBit      (rxBit),
    .rxStart    (rxStart),
    .rxErr      (rxErr)
  );

  pbc_datapath #(
    .CLK_PER_US (CLK_PER_US),
    .MARK_US    (MARK_US),
    .GAP_US     (GAP_US),
    .LEAD_US    (LEAD_US),
    .SYNC_US    (SYNC_US),
    .DATA_US    (DATA_US),
    .TMR_W      (TMR_W),
    .WIDTH_W    (WIDTH_W),
    .WIDTH_MAX  (WIDTH_MAX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .rxLine     (rxLine),
    .txDrive    (txDrive),
    .stat       (stat),
    .pulseWidth (pulseWidth)
  );

endmodule

// File: rtl/pulse_bit_codec_chk.sv
module pulse_bit_codec_chk (
  input logic clk,
  input logic rstN,
  input logic txReq,
  input logic txReady,
  input logic txDone,
  input logic txDrive,
  input logic rxBitValid,
  input logic rxStart,
  input logic rxErr
);

  logic anyStrobe;
  assign anyStrobe = rxBitValid | rxStart | rxErr;

  // R1: an idle transmitter never pulls the line
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !txDrive);

  // R4: acceptance makes the transmitter busy on the next cycle
  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && txReady) |=> !txReady);

  // R4: ready comes back only with the done pulse
  p_ready_with_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReady) |-> txDone);

  // R4: done pulse only while ready
  p_done_when_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txReady);

  // R10: receive strobes exclusive
  p_strobe_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxBitValid, rxStart, rxErr}));

  // R10: receive strobes last one cycle
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |=> !anyStrobe);

endmodule

bind pulse_bit_codec pulse_bit_codec_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txReq      (txReq),
  .txReady    (txReady),
  .txDone     (txDone),
  .txDrive    (txDrive),
  .rxBitValid (rxBitValid),
  .rxStart    (rxStart),
  .rxErr      (rxErr)
);

// File: tb/pulse_bit_codec_bench.sv
module pulse_bit_codec_bench;

  localparam int C = 2;
  localparam int Z = 32 * C;
  localparam int O = 19 * C;
  localparam int S = 169 * C;
  localparam int Z_LO = Z - Z / 4, Z_HI = Z + Z / 4;
  localparam int O_LO = O - O / 4, O_HI = O + O / 4;
  localparam int S_LO = S - S / 4, S_HI = S + S / 4;

  // Codes: 0 = bit 0, 1 = bit 1, 2 = start marker, 3 = error
  localparam int NVEC = 12;
  localparam logic [1:0] VEC [NVEC] = '{2'd2, 2'd0, 2'd1, 2'd1, 2'd0, 2'd2,
                                        2'd1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd1};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic txReq = 1'b0, txStart = 1'b0, txBit = 1'b0;
  logic txReady, txDone, txDrive;
  logic otherDrive = 1'b0;
  logic rxLine;
  logic rxBitValid, rxBit, rxStart, rxErr;

  assign rxLine = ~(txDrive | otherDrive);

  pulse_bit_codec #(.CLK_PER_US(C)) u_pulse_bit_codec (
    .clk(clk), .rstN(rstN), .txReq(txReq), .txStart(txStart), .txBit(txBit),
    .txReady(txReady), .txDone(txDone), .txDrive(txDrive), .rxLine(rxLine),
    .rxBitValid(rxBitValid), .rxBit(rxBit), .rxStart(rxStart), .rxErr(rxErr)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rxCode();
    if ($countones({rxBitValid, rxStart, rxErr}) > 1) return 9;
    if (rxBitValid) return rxBit ? 1 : 0;
    if (rxStart) return 2;
    if (rxErr) return 3;
    return -1;
  endfunction

  int gotCode [512];
  int gotN = 0;
  int expCode [512];
  int expN = 0;

  always @(negedge clk) begin
    if (rstN && rxCode() >= 0 && gotN < 512) begin
      gotCode[gotN] = rxCode();
      gotN++;
    end
  end

  task automatic sendSym(input bit isStart, input bit val, input bit jam, input int expRx);
    int total, bad, busyBad, expD;
    while (!txReady) @(negedge clk);
    txReq = 1'b1; txStart = isStart; txBit = val;
    @(negedge clk);
    txReq = 1'b0;
    total = isStart ? 189 * C : 38 * C;
    bad = 0; busyBad = 0;
    for (int i = 0; i < total; i++) begin
      if (isStart) expD = (i < 169 * C) ? 1 : 0;
      else if (i < 6 * C) expD = 0;
      else if (i < 25 * C) expD = 1;
      else expD = val ? 0 : 1;
      if (txDrive !== expD[0]) bad++;
      if (txReady !== 1'b0) busyBad++;
      if (i == 3) begin txReq = 1'b1; txStart = ~isStart; txBit = ~val; end
      if (i == 4) txReq = 1'b0;
      if (jam && i == 6 * C) otherDrive = 1'b1;
      @(negedge clk);
    end
    otherDrive = 1'b0;
    check(bad == 0, isStart ? "R3 start waveform" : "R2 bit waveform", bad, 0);
    check(busyBad == 0 && txReady && txDone, "R4 busy then ready+done",
          busyBad * 4 + 2 * int'(txReady) + int'(txDone), 3);
    expCode[expN] = expRx;
    expN++;
  endtask

  task automatic pulseTest(input int n, input int expRx, input string req);
    otherDrive = 1'b1;
    repeat (n) @(negedge clk);
    otherDrive = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(rxCode() == -1, "R5 no early strobe", rxCode(), -1);
    @(negedge clk);
    check(rxCode() == expRx, req, rxCode(), expRx);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    logic [15:0] lfsr;
    int mism;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(txDrive == 1'b0 && txReady == 1'b1, "R1 in reset", int'(txDrive), 0);
    rstN = 1'b1;
    mism = 0;
    repeat (8) begin
      @(negedge clk);
      if (txDrive || !txReady || txDone || rxCode() != -1) mism++;
    end
    check(mism == 0, "R1 idle after reset", mism, 0);

    // Table walk: loopback of markers and bits (R2, R3, R4, R11)
    for (int v = 0; v < NVEC; v++)
      sendSym(VEC[v] == 2'd2, VEC[v][0], 1'b0, int'(VEC[v]));

    // Random bits (R11)
    lfsr = 16'hACE1;
    for (int k = 0; k < 24; k++) begin
      sendSym(1'b0, lfsr[0], 1'b0, int'(lfsr[0]));
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end

    // R11: another node dominates a 1 bit's data segment, decoded as 0
    sendSym(1'b0, 1'b1, 1'b1, 0);
    sendSym(1'b1, 1'b0, 1'b0, 2);

    repeat (10) @(negedge clk);
    check(gotN == expN, "R11 strobe count", gotN, expN);
    mism = 0;
    for (int k = 0; k < expN; k++) if (gotCode[k] != expCode[k]) mism++;
    check(mism == 0, "R11 R6 R7 R8 loopback order", mism, 0);

    // Window boundaries
    pulseTest(1,        3, "R9 glitch error");
    pulseTest(O_LO - 1, 3, "R9 below bit-1 window");
    pulseTest(O_LO,     1, "R7 bit-1 low edge");
    pulseTest(O_HI,     1, "R7 bit-1 high edge");
    pulseTest(Z_LO,     0, "R6 bit-0 low edge");
    pulseTest(Z_HI,     0, "R6 bit-0 high edge");
    pulseTest(Z_HI + 1, 3, "R9 above bit-0 window");
    pulseTest(S_LO - 1, 3, "R9 below start window");
    pulseTest(S_LO,     2, "R8 start low edge");
    pulseTest(S_HI,     2, "R8 start high edge");
    pulseTest(S_HI + 1, 3, "R9 above start window");
    pulseTest(600,      3, "R9 saturated width");
    check(gotN < 512, "R10 strobe record", gotN, 0);

    // R1: reset during a start marker returns to idle, line released
    txReq = 1'b1; txStart = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
    repeat (20) @(negedge clk);
    check(txDrive == 1'b1, "R3 marker driving", int'(txDrive), 1);
    rstN = 1'b0;
    @(negedge clk);
    check(txDrive == 1'b0 && txReady == 1'b1, "R1 reset mid-symbol", int'(txDrive), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(rxCode() == -1, "R1 no strobe after reset", rxCode(), -1);

    finish();
  end

endmodule